// File: doc/BRIEF.md
# Dual-Space Program Counter Unit

This unit owns the program counter of a small core that can run code either from a 512-word local register memory or from a larger shared memory. Both memories sit in one flat address space. Any target whose bits above bit 8 are all zero is a local address, and any other target is a shared address. The long jump, the long calls and the returns pick the execution space on their own from the target they load. There is no separate instruction for entering or leaving shared-memory execution.

Each cycle the decode stage presents the decoded operation, a 16-bit immediate target, an optional prefix that supplies the upper target bits, and the PC of the instruction being decoded. When the decode strobe is high, the unit registers the next PC and the execution mode one clock later. It also raises a one-cycle flush pulse when control is transferred. Return addresses are kept in three places: a link register, two 4-entry hardware stacks, and a 9-bit return register for plain local calls. One-cycle write and pop pulses, aligned with the new PC, report every use of the link register and the stacks.

Top module: `dspc_unit`

## Requirements
- R1: After reset `next_pc` is 0, `shared_mode` is 0 (local), and `flush`, `lr_we`, `push_a`, `push_b`, `pop_a` and `pop_b` are all 0.
- R2: When `dec_valid` is high and the operation code is 0 (sequential), `next_pc` becomes `cur_pc`+1 on the following edge and the mode is unchanged. When `dec_valid` is low, `next_pc` and `shared_mode` hold.
- R3: The long jump (code 1) loads a target formed as {`ext_hi`, `imm_addr`} when `ext_valid` is 1, or as `imm_addr` zero-extended when `ext_valid` is 0. `shared_mode` becomes 1 exactly when target bits 23:9 are not all zero.
- R4: Code 2 calls the long target and saves `cur_pc`+1 in the link register. Code 5 jumps to the link register value, with the mode taken from its upper bits.
- R5: Code 3 and code 4 call the long target and push `cur_pc`+1 onto stack A and stack B respectively. Codes 6 and 7 pop stack A and stack B, jump to the popped address, and set the mode from it. Each stack is last-in first-out and independent of the other.
- R6: Each stack holds 4 entries. A push onto a full stack discards the oldest entry. A pop from an empty stack yields address 0, so the core lands in local mode.
- R7: Code 8 (short jump) loads `imm_addr[8:0]` zero-extended and always leaves the core in local mode, from either mode.
- R8: In local mode, code 9 (plain call) jumps to `imm_addr[8:0]` and keeps (`cur_pc`+1) mod 512 in a local return register. Code 10 (plain return) jumps to that register's value. Neither changes the mode. In shared mode both codes act as code 0 and leave the local return register untouched.
- R9: `flush` is high for exactly the one cycle after each taken transfer and low otherwise. Codes 11 to 15 act as code 0.
- R10: `lr_we`, `push_a`, `push_b`, `pop_a` and `pop_b` pulse for one cycle, aligned with the new `next_pc`, after codes 2, 3, 4, 6 and 7 respectively. At most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | 1 | Decode strobe; the operation below is acted on |
| op | input | 4 | Decoded control-transfer operation code |
| imm_addr | input | 16 | Immediate target address |
| ext_valid | input | 1 | Prefix word present |
| ext_hi | input | 8 | Upper target bits from the prefix |
| cur_pc | input | 24 | Address of the instruction being decoded |
| next_pc | output | 24 | Registered next program counter |
| shared_mode | output | 1 | 1 when running from shared memory |
| flush | output | 1 | One-cycle pulse after a taken transfer |
| lr_we | output | 1 | Link register written |
| push_a | output | 1 | Stack A pushed |
| push_b | output | 1 | Stack B pushed |
| pop_a | output | 1 | Stack A popped |
| pop_b | output | 1 | Stack B popped |

## Verification
A stack call can overflow the stack and switch the execution mode in the same cycle. The bench fills stack A with four calls to shared targets. It then makes a fifth call, to a local target, so the push that drops the oldest entry is also the cycle that leaves shared mode. The behavioural model, which keeps each stack as a bounded queue, predicts both the local PC and the later pop sequence that ends in address 0. The bench judges the cycle on the PC, the mode and the push pulse together.

// File: rtl/dspc_pkg.sv
package dspc_pkg;

    typedef enum logic [3:0] {
        OP_SEQ      = 4'd0,
        OP_LJMP     = 4'd1,
        OP_LCALL_LR = 4'd2,
        OP_LCALL_A  = 4'd3,
        OP_LCALL_B  = 4'd4,
        OP_RET_LR   = 4'd5,
        OP_RET_A    = 4'd6,
        OP_RET_B    = 4'd7,
        OP_SJMP     = 4'd8,
        OP_CALL     = 4'd9,
        OP_RET      = 4'd10
    } pc_op_e;

endpackage

// File: rtl/dspc_space_dec.sv
module dspc_space_dec #(
    parameter int ADDR_W  = 24,
    parameter int LOCAL_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_shared
);
    // Any set bit above the local window marks a shared-memory address.
    assign is_shared = |addr[ADDR_W-1:LOCAL_W];
endmodule

// File: rtl/dspc_ret_stack.sv
module dspc_ret_stack #(
    parameter int DEPTH = 4,
    parameter int W     = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     ent_q   [DEPTH];
    logic [W-1:0]     from_up [DEPTH];
    logic [W-1:0]     from_dn [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;

    // Entry 0 is the newest; pushes shift toward DEPTH-1, pops shift back.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        if (i == 0) begin : g_head
            assign from_up[i] = din;
        end else begin : g_body
            assign from_up[i] = ent_q[i-1];
        end
        if (i == DEPTH - 1) begin : g_tail
            assign from_dn[i] = '0;
        end else begin : g_inner
            assign from_dn[i] = ent_q[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[i] <= '0;
            end else if (push) begin
                ent_q[i] <= from_up[i];
            end else if (pop) begin
                ent_q[i] <= from_dn[i];
            end
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (push && (cnt_q < CNT_W'(DEPTH))) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else if (pop && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign top = (cnt_q != '0) ? ent_q[0] : '0;
endmodule

// File: rtl/dspc_unit.sv
module dspc_unit
    import dspc_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int LOCAL_W = 9,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_valid,
    input  logic [3:0]         op,
    input  logic [15:0]        imm_addr,
    input  logic               ext_valid,
    input  logic [ADDR_W-17:0] ext_hi,
    input  logic [ADDR_W-1:0]  cur_pc,
    output logic [ADDR_W-1:0]  next_pc,
    output logic               shared_mode,
    output logic               flush,
    output logic               lr_we,
    output logic               push_a,
    output logic               push_b,
    output logic               pop_a,
    output logic               pop_b
);
    localparam int EXT_W = ADDR_W - 16;
    localparam int N_STK = 2;

    typedef struct packed {
        logic [ADDR_W-1:0]  pc;
        logic               shared;
        logic               flush;
        logic               lr_we;
        logic               push_a;
        logic               push_b;
        logic               pop_a;
        logic               pop_b;
        logic [ADDR_W-1:0]  lr;
        logic [LOCAL_W-1:0] lret;
    } pcu_state_t;

    pcu_state_t        st_d;
    pcu_state_t        st_q;
    logic [ADDR_W-1:0] long_tgt;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] tgt;
    logic              tgt_shared;
    logic              taken;
    logic [N_STK-1:0]  stk_push;
    logic [N_STK-1:0]  stk_pop;
    logic [ADDR_W-1:0] stk_top [N_STK];

    for (genvar s = 0; s < N_STK; s++) begin : g_stk
        dspc_ret_stack #(
            .DEPTH (DEPTH),
            .W     (ADDR_W)
        ) i_stk (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (stk_push[s]),
            .pop   (stk_pop[s]),
            .din   (seq_pc),
            .top   (stk_top[s])
        );
    end

    dspc_space_dec #(
        .ADDR_W  (ADDR_W),
        .LOCAL_W (LOCAL_W)
    ) i_space (
        .addr      (tgt),
        .is_shared (tgt_shared)
    );

    assign long_tgt = {(ext_valid ? ext_hi : EXT_W'(0)), imm_addr};
    assign seq_pc   = cur_pc + ADDR_W'(1);

    always_comb begin
        st_d        = st_q;
        st_d.flush  = 1'b0;
        st_d.lr_we  = 1'b0;
        st_d.push_a = 1'b0;
        st_d.push_b = 1'b0;
        st_d.pop_a  = 1'b0;
        st_d.pop_b  = 1'b0;
        tgt         = '0;
        taken       = 1'b0;
        stk_push    = '0;
        stk_pop     = '0;

        if (dec_valid) begin
            st_d.pc = seq_pc;
            case (op)
                OP_LJMP: begin
                    tgt   = long_tgt;
                    taken = 1'b1;
                end
                OP_LCALL_LR: begin
                    tgt        = long_tgt;
                    taken      = 1'b1;
                    st_d.lr    = seq_pc;
                    st_d.lr_we = 1'b1;
                end
                OP_LCALL_A: begin
                    tgt         = long_tgt;
                    taken       = 1'b1;
                    stk_push[0] = 1'b1;
                    st_d.push_a = 1'b1;
                end
                OP_LCALL_B: begin
                    tgt         = long_tgt;
                    taken       = 1'b1;
                    stk_push[1] = 1'b1;
                    st_d.push_b = 1'b1;
                end
                OP_RET_LR: begin
                    tgt   = st_q.lr;
                    taken = 1'b1;
                end
                OP_RET_A: begin
                    tgt        = stk_top[0];
                    taken      = 1'b1;
                    stk_pop[0] = 1'b1;
                    st_d.pop_a = 1'b1;
                end
                OP_RET_B: begin
                    tgt        = stk_top[1];
                    taken      = 1'b1;
                    stk_pop[1] = 1'b1;
                    st_d.pop_b = 1'b1;
                end
                OP_SJMP: begin
                    tgt   = ADDR_W'(imm_addr[LOCAL_W-1:0]);
                    taken = 1'b1;
                end
                OP_CALL: begin
                    if (!st_q.shared) begin
                        tgt       = ADDR_W'(imm_addr[LOCAL_W-1:0]);
                        taken     = 1'b1;
                        st_d.lret = seq_pc[LOCAL_W-1:0];
                    end
                end
                OP_RET: begin
                    if (!st_q.shared) begin
                        tgt   = ADDR_W'(st_q.lret);
                        taken = 1'b1;
                    end
                end
                default: begin
                end
            endcase

            if (taken) begin
                st_d.pc     = tgt;
                st_d.shared = tgt_shared;
                st_d.flush  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_pc     = st_q.pc;
    assign shared_mode = st_q.shared;
    assign flush       = st_q.flush;
    assign lr_we       = st_q.lr_we;
    assign push_a      = st_q.push_a;
    assign push_b      = st_q.push_b;
    assign pop_a       = st_q.pop_a;
    assign pop_b       = st_q.pop_b;
endmodule

// File: rtl/dspc_unit_chk.sv
module dspc_unit_chk #(
    parameter int ADDR_W  = 24,
    parameter int LOCAL_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic [3:0]        op,
    input logic [ADDR_W-1:0] cur_pc,
    input logic [ADDR_W-1:0] next_pc,
    input logic              shared_mode,
    input logic              flush,
    input logic              lr_we,
    input logic              push_a,
    input logic              push_b,
    input logic              pop_a,
    input logic              pop_b
);
    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && op == 4'd0) |=> (next_pc == $past(cur_pc) + ADDR_W'(1)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> ($stable(next_pc) && $stable(shared_mode)));

    assert_mode_follows_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (shared_mode == (next_pc[ADDR_W-1:LOCAL_W] != '0)));

    assert_short_jump_local_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && op == 4'd8) |=> (!shared_mode && next_pc[ADDR_W-1:LOCAL_W] == '0));

    assert_plain_keeps_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (op == 4'd9 || op == 4'd10)) |=> $stable(shared_mode));

    assert_no_flush_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> !flush);

    assert_ctrl_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lr_we, push_a, push_b, pop_a, pop_b}));

    assert_ctrl_with_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lr_we || push_a || push_b || pop_a || pop_b) |-> flush);
endmodule

bind dspc_unit dspc_unit_chk #(
    .ADDR_W  (ADDR_W),
    .LOCAL_W (LOCAL_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dec_valid   (dec_valid),
    .op          (op),
    .cur_pc      (cur_pc),
    .next_pc     (next_pc),
    .shared_mode (shared_mode),
    .flush       (flush),
    .lr_we       (lr_we),
    .push_a      (push_a),
    .push_b      (push_b),
    .pop_a       (pop_a),
    .pop_b       (pop_b)
);

// File: tb/test_dspc_unit.sv
`timescale 1ns/1ps
module test_dspc_unit;
    localparam longint AMASK = 64'hFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [15:0] imm_addr = '0;
    logic        ext_valid = 1'b0;
    logic [7:0]  ext_hi = '0;
    logic [23:0] cur_pc = '0;
    logic [23:0] next_pc;
    logic        shared_mode;
    logic        flush;
    logic        lr_we;
    logic        push_a;
    logic        push_b;
    logic        pop_a;
    logic        pop_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural reference state
    longint m_pc = 0;
    bit     m_shared = 0;
    longint m_lr = 0;
    longint m_lret = 0;
    longint qa[$];
    longint qb[$];
    bit     e_flush = 0;
    logic [4:0] e_ctrl = '0;

    always #2 clk = ~clk;

    dspc_unit i_dspc_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec_valid   (dec_valid),
        .op          (op),
        .imm_addr    (imm_addr),
        .ext_valid   (ext_valid),
        .ext_hi      (ext_hi),
        .cur_pc      (cur_pc),
        .next_pc     (next_pc),
        .shared_mode (shared_mode),
        .flush       (flush),
        .lr_we       (lr_we),
        .push_a      (push_a),
        .push_b      (push_b),
        .pop_a       (pop_a),
        .pop_b       (pop_b)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare(input string req);
        chk(req, "next_pc", longint'(next_pc), m_pc);
        chk(req, "shared_mode", longint'(shared_mode), longint'(m_shared));
        chk((req == "R1") ? "R1" : "R9", "flush", longint'(flush), longint'(e_flush));
        chk((req == "R1") ? "R1" : "R10", "ctrl", longint'({lr_we, push_a, push_b, pop_a, pop_b}),
            longint'(e_ctrl));
    endtask

    function automatic void push_q(ref longint q[$], input longint v);
        q.push_front(v);
        if (q.size() > 4) void'(q.pop_back());
    endfunction

    function automatic longint pop_q(ref longint q[$]);
        if (q.size() == 0) return 0;
        return q.pop_front();
    endfunction

    function automatic void model(input bit v, input int o, input longint imm, input bit ev,
                                  input longint eh, input longint pc);
        longint seq;
        longint lng;
        longint tgt;
        bit taken;
        e_flush = 0;
        e_ctrl = '0;
        if (!v) return;
        seq = (pc + 1) & AMASK;
        lng = ev ? ((eh << 16) | imm) : imm;
        tgt = 0;
        taken = 0;
        case (o)
            1: begin tgt = lng; taken = 1; end
            2: begin tgt = lng; taken = 1; m_lr = seq; e_ctrl = 5'b10000; end
            3: begin tgt = lng; taken = 1; push_q(qa, seq); e_ctrl = 5'b01000; end
            4: begin tgt = lng; taken = 1; push_q(qb, seq); e_ctrl = 5'b00100; end
            5: begin tgt = m_lr; taken = 1; end
            6: begin tgt = pop_q(qa); taken = 1; e_ctrl = 5'b00010; end
            7: begin tgt = pop_q(qb); taken = 1; e_ctrl = 5'b00001; end
            8: begin tgt = imm & 'h1FF; taken = 1; end
            9: if (!m_shared) begin tgt = imm & 'h1FF; taken = 1; m_lret = seq & 'h1FF; end
            10: if (!m_shared) begin tgt = m_lret; taken = 1; end
            default: ;
        endcase
        if (taken) begin
            m_pc = tgt;
            m_shared = (tgt >> 9) != 0;
            e_flush = 1;
        end else begin
            m_pc = seq;
        end
    endfunction

    task automatic step(input string req, input bit v, input int o, input longint imm,
                        input bit ev, input longint eh, input longint pc);
        @(negedge clk);
        dec_valid = v;
        op = o[3:0];
        imm_addr = imm[15:0];
        ext_valid = ev;
        ext_hi = eh[7:0];
        cur_pc = pc[23:0];
        model(v, o, imm, ev, eh, pc);
        @(negedge clk);
        compare(req);
        dec_valid = 1'b0;
        e_flush = 0;
        e_ctrl = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        step("R2", 1, 0, 0, 0, 0, 5);
        step("R2", 0, 0, 'h1234, 0, 0, 'h77);
        step("R3", 1, 1, 'h0200, 0, 0, m_pc);
        step("R3", 1, 1, 'h01FF, 0, 'h5A, m_pc);
        step("R3", 1, 1, 'h0010, 1, 'h01, m_pc);
        step("R4", 1, 2, 'h0050, 0, 0, m_pc);
        step("R4", 1, 5, 0, 0, 0, m_pc);
        step("R5", 1, 3, 'h0400, 0, 0, m_pc);
        step("R5", 1, 4, 'h0500, 0, 0, m_pc);
        step("R5", 1, 3, 'h0040, 0, 0, m_pc);
        step("R5", 1, 6, 0, 0, 0, m_pc);
        step("R5", 1, 7, 0, 0, 0, m_pc);
        step("R5", 1, 6, 0, 0, 0, m_pc);
        step("R6", 1, 6, 0, 0, 0, m_pc);
        step("R6", 1, 7, 0, 0, 0, m_pc);
        // Fill stack A; the fifth call overflows it and returns to local mode at once.
        for (int i = 0; i < 5; i++) begin
            step("R6", 1, 3, (i < 4) ? ('h2000 + i * 'h100) : 'h0100, 0, 0, m_pc);
        end
        for (int i = 0; i < 5; i++) begin
            step("R6", 1, 6, 0, 0, 0, m_pc);
        end
        step("R7", 1, 1, 'h3000, 0, 0, m_pc);
        step("R7", 1, 8, 'h3ABC, 0, 0, m_pc);
        step("R8", 1, 9, 'h0040, 0, 0, m_pc);
        step("R8", 1, 10, 0, 0, 0, m_pc);
        step("R8", 1, 1, 'h4000, 0, 0, m_pc);
        step("R8", 1, 9, 'h0077, 0, 0, m_pc);
        step("R8", 1, 10, 0, 0, 0, m_pc);
        step("R7", 1, 8, 'h0020, 0, 0, m_pc);
        step("R8", 1, 10, 0, 0, 0, m_pc);
        step("R9", 1, 12, 'h0123, 1, 'h33, m_pc);
        step("R9", 1, 15, 'h0123, 0, 0, m_pc);
        finish_run();
    end
endmodule